// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits in front of eighteen counter channels. The channels are arranged as three groups. Each group holds two counter chips, and each chip has three channels. For every channel, the block holds one clock selection and one gate selection. It turns each clock selection into a single-cycle count enable and each gate selection into a gate level. Software programs a selection with one byte written to a per-group register. That byte names the chip, the channel and a 5-bit source number, so one write changes exactly one channel's routing.

Clock sources are either the channel's own external clock pin or a tick from a shared prescaler chain. The pin is synchronised and edge-detected. The prescaler runs off the system clock and produces a fastest rate, half that rate, and four further rates each a decade slower. Gate sources are either a constant high or the channel's synchronised external gate pin. A separate one-bit register widens the source field from 3 to 5 bits. The counters themselves live outside the block.

Top module: `srcmux_router`

## Requirements
- R1: After reset, every stored clock and gate selection is 0 and the range-extension bit is 0. During reset, all gate_o bits are 1 and all clk_en_o bits are 0.
- R2: The selection byte is decoded as follows:
  - A write to address 0x18+g (g = 0..2) sets a clock selection. A write to 0x1B+g sets a gate selection.
  - Bit 5 is the chip, bits 4:3 are the channel, bits 2:0 are source bits 2:0, and bits 7:6 are source bits 4:3.
  - The target is counter index g*6 + chip*3 + channel. No other selection changes.
  - The new selection drives the outputs from the cycle after the write edge.
- R3: A write to a selection address with a channel field of 3 changes no selection.
- R4: Bit 0 of a write to address 0x20 sets the range-extension bit. While that bit is 0, source bits 4:3 are stored as 0.
- R5: Clock source 0 routes the counter's external clock pin through a two-flop synchroniser. A rising edge produces exactly one cycle of clk_en_o. A pin that rises before edge e gives clk_en_o high in the cycle after edge e+1.
- R6: Clock sources 1 to 5 route the prescaler ticks, each one cycle long. With n counted as clock edges since reset, source 1 fires when (n+1) is a multiple of 2*BASE_DIV. Source k (2..5) fires when (n+1) is a multiple of 2*BASE_DIV*DECADE_DIV^(k-1).
- R7: Clock source 11 routes the fastest tick, which fires when (n+1) is a multiple of BASE_DIV. This source is only reachable with the range-extension bit set.
- R8: Gate source 0 drives gate_o high. Gate source 1 drives gate_o with the gate pin delayed by two synchroniser flops.
- R9: Any other clock source gives clk_en_o 0, and any other gate source gives gate_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 8 | Register write data |
| ext_clk_i | input | 18 | External clock pin per counter, asynchronous |
| ext_gate_i | input | 18 | External gate pin per counter, asynchronous |
| clk_en_o | output | 18 | Selected count enable per counter, one cycle per event |
| gate_o | output | 18 | Selected gate level per counter |

## Verification
The assertions place no constraint on the external pins. They are treated as fully asynchronous, so the single-cycle-enable property must hold for any pin waveform, and the stimulus redraws every pin from a pseudo-random sequence each cycle. The properties do rely on writes being presented as clean single-cycle strobes with stable address and data around the clock edge. The bench therefore changes wr_en_i, addr_i and wdata_i only just after the falling edge. The prescaler gap property assumes BASE_DIV is at least 1, so the half-rate tick can never fire on two consecutive cycles.

// File: rtl/srcmux_pkg.sv
package srcmux_pkg;
  localparam int unsigned N_GROUPS       = 3;
  localparam int unsigned CHIPS_PER_GRP  = 2;
  localparam int unsigned CHANS_PER_CHIP = 3;
  localparam int unsigned CNT_PER_GROUP  = CHIPS_PER_GRP * CHANS_PER_CHIP;
  localparam int unsigned N_CNT          = N_GROUPS * CNT_PER_GROUP;
  localparam int unsigned IDX_W          = $clog2(N_CNT);
  localparam int unsigned SRC_W          = 5;
  localparam int unsigned N_TICKS        = 6;
  localparam int unsigned ADDR_W         = 6;

  localparam logic [ADDR_W-1:0] ADDR_CLK0  = 6'h18;
  localparam logic [ADDR_W-1:0] ADDR_GATE0 = 6'h1B;
  localparam logic [ADDR_W-1:0] ADDR_EXT   = 6'h20;

  typedef logic [SRC_W-1:0] src_t;

  typedef struct packed {
    logic [1:0] src_hi;
    logic       chip;
    logic [1:0] chan;
    logic [2:0] src_lo;
  } sel_byte_t;
endpackage

// File: rtl/srcmux_tick_gen.sv
module srcmux_tick_gen
  import srcmux_pkg::*;
#(
  parameter int unsigned BASE_DIV   = 2,
  parameter int unsigned DECADE_DIV = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [N_TICKS-1:0] tick_o
);
  localparam int unsigned MAX_R = (BASE_DIV > DECADE_DIV) ? BASE_DIV : DECADE_DIV;
  localparam int unsigned CW    = $clog2(MAX_R + 1) + 1;

  logic [N_TICKS:0] en_chain;
  assign en_chain[0] = 1'b1;
  assign tick_o      = en_chain[N_TICKS:1];

  for (genvar k = 0; k < N_TICKS; k++) begin : g_stage
    localparam int unsigned RATIO = (k == 0) ? BASE_DIV : ((k == 1) ? 2 : DECADE_DIV);
    logic [CW-1:0] cnt_q;
    logic          wrap;
    assign wrap          = (cnt_q == CW'(RATIO - 1));
    assign en_chain[k+1] = en_chain[k] & wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (en_chain[k]) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    if (k >= 1) begin : g_chk
      assert_tick_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[k] |=> !tick_o[k]);
    end
  end
endmodule

// File: rtl/srcmux_pin_sync.sv
module srcmux_pin_sync #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] clk_pin_i,
  input  logic [N-1:0] gate_pin_i,
  output logic [N-1:0] clk_rise_o,
  output logic [N-1:0] gate_lvl_o
);
  logic [N-1:0] c1_q, c2_q, c3_q, g1_q, g2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '0; c2_q <= '0; c3_q <= '0;
      g1_q <= '0; g2_q <= '0;
    end else begin
      c1_q <= clk_pin_i;  c2_q <= c1_q;  c3_q <= c2_q;
      g1_q <= gate_pin_i; g2_q <= g1_q;
    end
  end

  assign clk_rise_o = c2_q & ~c3_q;
  assign gate_lvl_o = g2_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_edge_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_rise_o[i] |=> !clk_rise_o[i]);
  end
endmodule

// File: rtl/srcmux_sel_regs.sv
module srcmux_sel_regs
  import srcmux_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [7:0]                   wdata_i,
  output logic [N_CNT-1:0][SRC_W-1:0]  clk_sel_o,
  output logic [N_CNT-1:0][SRC_W-1:0]  gate_sel_o
);
  sel_byte_t        wb;
  logic             ext_q, in_clk, in_gate, chan_ok;
  logic [1:0]       grp;
  logic [IDX_W-1:0] idx;
  src_t             new_src;

  assign wb      = sel_byte_t'(wdata_i);
  assign in_clk  = wr_en_i && (addr_i >= ADDR_CLK0)  && (addr_i < ADDR_CLK0  + ADDR_W'(N_GROUPS));
  assign in_gate = wr_en_i && (addr_i >= ADDR_GATE0) && (addr_i < ADDR_GATE0 + ADDR_W'(N_GROUPS));
  assign grp     = 2'(in_clk ? (addr_i - ADDR_CLK0) : (addr_i - ADDR_GATE0));
  assign chan_ok = (wb.chan < 2'(CHANS_PER_CHIP));
  assign idx     = IDX_W'(grp) * IDX_W'(CNT_PER_GROUP)
                 + IDX_W'(wb.chip) * IDX_W'(CHANS_PER_CHIP) + IDX_W'(wb.chan);
  // basic range: upper source bits dropped at write time
  assign new_src = {ext_q ? wb.src_hi : 2'b00, wb.src_lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ext_q <= 1'b0;
    else if (wr_en_i && (addr_i == ADDR_EXT)) ext_q <= wdata_i[0];
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    logic wr_c, wr_g;
    assign wr_c = in_clk  && chan_ok && (idx == IDX_W'(i));
    assign wr_g = in_gate && chan_ok && (idx == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        clk_sel_o[i]  <= '0;
        gate_sel_o[i] <= '0;
      end else begin
        if (wr_c) clk_sel_o[i]  <= new_src;
        if (wr_g) gate_sel_o[i] <= new_src;
      end
    end

    assert_basic_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((wr_c || wr_g) && !ext_q) |=>
        (wr_c ? clk_sel_o[i][4:3] : gate_sel_o[i][4:3]) == 2'b00);
  end

  assert_ch3_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wb.chan == 2'd3) |=> ($stable(clk_sel_o) && $stable(gate_sel_o)));
endmodule

// File: rtl/srcmux_route.sv
module srcmux_route
  import srcmux_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CNT-1:0][SRC_W-1:0] clk_sel_i,
  input  logic [N_CNT-1:0][SRC_W-1:0] gate_sel_i,
  input  logic [N_TICKS-1:0]          tick_i,
  input  logic [N_CNT-1:0]            pin_rise_i,
  input  logic [N_CNT-1:0]            pin_gate_i,
  output logic [N_CNT-1:0]            clk_en_o,
  output logic [N_CNT-1:0]            gate_o
);
  for (genvar i = 0; i < N_CNT; i++) begin : g_mux
    always_comb begin
      case (clk_sel_i[i])
        5'd0:    clk_en_o[i] = pin_rise_i[i];
        5'd1:    clk_en_o[i] = tick_i[1];
        5'd2:    clk_en_o[i] = tick_i[2];
        5'd3:    clk_en_o[i] = tick_i[3];
        5'd4:    clk_en_o[i] = tick_i[4];
        5'd5:    clk_en_o[i] = tick_i[5];
        5'd11:   clk_en_o[i] = tick_i[0];
        default: clk_en_o[i] = 1'b0;
      endcase
      case (gate_sel_i[i])
        5'd0:    gate_o[i] = 1'b1;
        5'd1:    gate_o[i] = pin_gate_i[i];
        default: gate_o[i] = 1'b0;
      endcase
    end

    assert_gate_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_sel_i[i] == 5'd0) |-> gate_o[i]);
    assert_unimpl_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_sel_i[i] > 5'd5 && clk_sel_i[i] != 5'd11) |-> !clk_en_o[i]);
    assert_gate_unimpl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_sel_i[i] > 5'd1) |-> !gate_o[i]);
  end
endmodule

// File: rtl/srcmux_router.sv
module srcmux_router
  import srcmux_pkg::*;
#(
  parameter int unsigned BASE_DIV   = 2,
  parameter int unsigned DECADE_DIV = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [N_CNT-1:0]  ext_clk_i,
  input  logic [N_CNT-1:0]  ext_gate_i,
  output logic [N_CNT-1:0]  clk_en_o,
  output logic [N_CNT-1:0]  gate_o
);
  logic [N_CNT-1:0][SRC_W-1:0] clk_sel, gate_sel;
  logic [N_TICKS-1:0]          tick;
  logic [N_CNT-1:0]            pin_rise, pin_gate;

  srcmux_sel_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .clk_sel_o(clk_sel), .gate_sel_o(gate_sel)
  );

  srcmux_tick_gen #(.BASE_DIV(BASE_DIV), .DECADE_DIV(DECADE_DIV)) u_ticks (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  srcmux_pin_sync #(.N(N_CNT)) u_sync (
    .clk_i, .rst_ni, .clk_pin_i(ext_clk_i), .gate_pin_i(ext_gate_i),
    .clk_rise_o(pin_rise), .gate_lvl_o(pin_gate)
  );

  srcmux_route u_route (
    .clk_i, .rst_ni, .clk_sel_i(clk_sel), .gate_sel_i(gate_sel), .tick_i(tick),
    .pin_rise_i(pin_rise), .pin_gate_i(pin_gate), .clk_en_o, .gate_o
  );
endmodule

// File: tb/srcmux_router_tb.sv
module srcmux_router_tb_top;
  import srcmux_pkg::*;

  localparam int unsigned B = 2;
  localparam int unsigned D = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [N_CNT-1:0]  ext_clk_i = '0, ext_gate_i = '0;
  logic [N_CNT-1:0]  clk_en_o, gate_o;

  always #10 clk_i = ~clk_i;

  srcmux_router #(.BASE_DIV(B), .DECADE_DIV(D)) dut_i (.*);

  int     errors = 0, checks = 0;
  bit     done = 0;
  string  ph_tag = "R1";
  longint n = 0;
  int     m_clk [N_CNT];
  int     m_gate[N_CNT];
  bit     m_ext = 0;
  logic [N_CNT-1:0] m_c1 = '0, m_c2 = '0, m_c3 = '0, m_g1 = '0, m_g2 = '0;
  int unsigned lfsr = 32'h1234_5678;

  function automatic bit tk(int k, longint cyc);
    longint p = (k == 0) ? B : 2 * B;
    for (int j = 2; j <= k; j++) p = p * D;
    return ((cyc + 1) % p) == 0;
  endfunction

  task automatic chk(bit ok, string req, int idx, logic act, logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) counter %0d: actual=%0b expected=%0b", req, ph_tag, idx, act, exp);
    end
  endtask

  task automatic model_edge();
    if (wr_en_i) begin
      int a = int'(addr_i);
      int ch = (int'(wdata_i) >> 3) & 3;
      int chip = (int'(wdata_i) >> 5) & 1;
      int src = (int'(wdata_i) & 7) | (m_ext ? (((int'(wdata_i) >> 6) & 3) << 3) : 0);
      if (a == 'h20) m_ext = wdata_i[0];
      else if (ch != 3) begin
        if (a >= 'h18 && a <= 'h1A) m_clk[(a - 'h18) * 6 + chip * 3 + ch] = src;
        if (a >= 'h1B && a <= 'h1D) m_gate[(a - 'h1B) * 6 + chip * 3 + ch] = src;
      end
    end
    m_c3 = m_c2; m_c2 = m_c1; m_c1 = ext_clk_i;
    m_g2 = m_g1; m_g1 = ext_gate_i;
    n++;
  endtask

  task automatic compare();
    for (int i = 0; i < N_CNT; i++) begin
      logic ec, eg;
      string rc, rg;
      case (m_clk[i])
        0:             begin ec = m_c2[i] & ~m_c3[i]; rc = "R5"; end
        1, 2, 3, 4, 5: begin ec = tk(m_clk[i], n);    rc = "R6"; end
        11:            begin ec = tk(0, n);           rc = "R7"; end
        default:       begin ec = 1'b0;               rc = "R9"; end
      endcase
      case (m_gate[i])
        0:       begin eg = 1'b1;    rg = "R8"; end
        1:       begin eg = m_g2[i]; rg = "R8"; end
        default: begin eg = 1'b0;    rg = "R9"; end
      endcase
      chk(clk_en_o[i] === ec, rc, i, clk_en_o[i], ec);
      chk(gate_o[i] === eg, rg, i, gate_o[i], eg);
    end
  endtask

  task automatic step();
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    ext_clk_i  = lfsr[N_CNT-1:0];
    ext_gate_i = lfsr[31 -: N_CNT];
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare();
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic run(int cyc);
    for (int c = 0; c < cyc; c++) step();
  endtask

  initial begin
    for (int i = 0; i < N_CNT; i++) begin m_clk[i] = 0; m_gate[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R1: outputs during reset
    chk(gate_o === '1, "R1", -1, &gate_o, 1'b1);
    chk(clk_en_o === '0, "R1", -1, |clk_en_o, 1'b0);
    rst_ni = 1'b1;
    ph_tag = "R1"; run(20);
    ph_tag = "R2";
    wr(6'h18, 8'h01); wr(6'h18, 8'h0A); wr(6'h18, 8'h13);
    wr(6'h19, 8'h24); wr(6'h19, 8'h35);
    wr(6'h1A, 8'h0E); wr(6'h1A, 8'h37);
    run(60);
    ph_tag = "R3";
    wr(6'h1A, 8'h19); wr(6'h1C, 8'h19); run(10);
    ph_tag = "R4";
    wr(6'h1A, 8'h43); run(20);
    ph_tag = "R7";
    wr(6'h20, 8'h01); wr(6'h1A, 8'h63); wr(6'h1A, 8'h55); wr(6'h18, 8'h69);
    run(30);
    ph_tag = "R8";
    wr(6'h1B, 8'h01); wr(6'h1C, 8'h0D); wr(6'h1D, 8'hB1);
    run(30);
    ph_tag = "R6";
    run(42000);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 250000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (phase %s): actual=running expected=finished", ph_tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule